// File: doc/BRIEF.md
# Masked Alarm Comparator and Interrupt Router

This block sits beside a BCD timekeeping counter. On every tick strobe it compares two programmed alarm sets against the live time fields. The first alarm covers seconds, minutes, hours and a calendar field. The second covers minutes, hours and a calendar field. A field whose mask bit is set drops out of the comparison. A match sets a sticky flag in a status register, and the flag stays set until software clears it.

Two active-low open-drain outputs, modelled as pull-down enables, carry the result. A routing bit picks one of two plans. In the first, output 1 carries a square wave chosen from four prescaler taps and output 2 carries the OR of both enabled alarm flags. In the second, each alarm gets its own output.

The block also keeps an oscillator-fail flag that hardware sets and software clears. A control bit drives a stop request toward the oscillator.

Top module: `alarm_irq_router`

## Requirements
- R1: After reset, the control register (address 7) reads 0x18, the status register (address 8) reads 0x80, the alarm registers (addresses 0..6) read 0x00, and addresses 9..15 read 0x00.
- R2: Register map. Address 0 holds the alarm-1 seconds byte, 1 its minutes, 2 its hours and 3 its day/date. Address 4 holds the alarm-2 minutes byte, 5 its hours and 6 its day/date. For seconds, minutes and hours, bits 6:0 are compared with the matching 7-bit time input.
- R3: In each day/date byte, bit 6 selects the compared field. With bit 6 at 1, bits 2:0 are compared with the weekday input. With bit 6 at 0, bits 5:0 are compared with the date input.
- R4: Bit 7 of every alarm byte is a mask: 1 removes that field from the comparison. With all four alarm-1 masks set, alarm 1 matches on every tick. With all three alarm-2 masks set, alarm 2 matches only on a tick where seconds equal 00. Alarm 2 always requires seconds equal to 00.
- R5: Matches are evaluated only in a cycle with tick high. A match sets status bit 0 (alarm 1) or bit 1 (alarm 2), and a set flag stays set until it is cleared.
- R6: Writing status with a 0 in bit 0 or bit 1 clears that flag. Writing a 1 has no effect. A match in the same cycle as a clearing write leaves the flag set.
- R7: Control bits 4:3 select the wave: 11 selects the 32768 Hz tap, 10 the 8192 Hz tap, 01 the 4096 Hz tap and 00 the 1 Hz tap.
- R8: With control bit 2 at 0, output 1 drives low exactly while the selected wave is low. Output 2 drives low for (status bit 0 and control bit 0) or (status bit 1 and control bit 1).
- R9: With control bit 2 at 1, output 1 drives low for (status bit 1 and control bit 1), and output 2 drives low for (status bit 0 and control bit 0). Otherwise each output is released.
- R10: Status bit 7 is set in any cycle where osc_running is low. A written 0 in bit 7 clears it only if osc_running is high in that cycle.
- R11: Control bit 7 drives osc_stop. Control bits 6:5 and status bits 6:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle strobe: time fields have just advanced |
| t_sec | input | 7 | BCD seconds |
| t_min | input | 7 | BCD minutes |
| t_hour | input | 7 | Hour byte, bits 6:0 |
| t_wday | input | 3 | Day of week |
| t_date | input | 6 | BCD date |
| tap_32k | input | 1 | 32768 Hz prescaler tap |
| tap_8k | input | 1 | 8192 Hz prescaler tap |
| tap_4k | input | 1 | 4096 Hz prescaler tap |
| tap_1hz | input | 1 | 1 Hz tap, aligned to time writes |
| osc_running | input | 1 | High while oscillation is present |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| osc_stop | output | 1 | Oscillator stop request (control bit 7) |
| out1_pd | output | 1 | Output 1 pull-down enable, 1 drives low |
| out2_pd | output | 1 | Output 2 pull-down enable, 1 drives low |

## Verification
A corrupted compare term or a wrong day/date select appears as a status flag that differs from the model on the next status read after the offending tick, one cycle later. The same fault shows on out2_pd in that cycle whenever the alarm's enable is set. A stuck or lost flag persists at the ports until a clearing write, so a mixed stream of random writes, ticks and clears exposes it within a few operations. Errors in routing or rate selection appear combinationally on out1_pd and out2_pd as soon as the taps or control change.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int TIME_W   = 7;
  localparam int WDAY_W   = 3;
  localparam int DATE_W   = 6;
  localparam int NUM_ALM  = 7;
  localparam int NUM_TAPS = 4;
  localparam int RATE_W   = $clog2(NUM_TAPS);

  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(8);

  localparam logic [DATA_W-1:0] CTRL_RESET = 8'h18;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 8'h9F;

  localparam int CB_OSC_STOP = 7;
  localparam int CB_RATE_LO  = 3;
  localparam int CB_SEP      = 2;
  localparam int CB_IE2      = 1;
  localparam int CB_IE1      = 0;

  localparam int SB_OSF = 7;
  localparam int SB_A2  = 1;
  localparam int SB_A1  = 0;

  localparam int MASK_BIT = 7;
  localparam int SEL_BIT  = 6;
endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import alm_pkg::*;
(
  input  logic [DATA_W-1:0] sec_byte,
  input  logic [DATA_W-1:0] min_byte,
  input  logic [DATA_W-1:0] hour_byte,
  input  logic [DATA_W-1:0] dd_byte,
  input  logic [TIME_W-1:0] t_sec,
  input  logic [TIME_W-1:0] t_min,
  input  logic [TIME_W-1:0] t_hour,
  input  logic [WDAY_W-1:0] t_wday,
  input  logic [DATE_W-1:0] t_date,
  output logic              hit
);
  logic sec_ok, min_ok, hour_ok, cal_ok, cal_eq;

  always_comb begin
    sec_ok  = sec_byte[MASK_BIT]  || (sec_byte[TIME_W-1:0]  == t_sec);
    min_ok  = min_byte[MASK_BIT]  || (min_byte[TIME_W-1:0]  == t_min);
    hour_ok = hour_byte[MASK_BIT] || (hour_byte[TIME_W-1:0] == t_hour);
    if (dd_byte[SEL_BIT]) cal_eq = (dd_byte[WDAY_W-1:0] == t_wday);
    else                  cal_eq = (dd_byte[DATE_W-1:0] == t_date);
    cal_ok  = dd_byte[MASK_BIT] || cal_eq;
    hit     = sec_ok && min_ok && hour_ok && cal_ok;
  end
endmodule

// File: rtl/irq_route.sv
module irq_route
  import alm_pkg::*;
(
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [RATE_W-1:0]   rate,
  input  logic                sep,
  input  logic                req1,
  input  logic                req2,
  output logic                out1_pd,
  output logic                out2_pd
);
  logic wave;

  always_comb begin
    wave = taps[rate];
    if (sep) begin
      out1_pd = req2;
      out2_pd = req1;
    end else begin
      out1_pd = !wave;
      out2_pd = req1 || req2;
    end
  end
endmodule

// File: rtl/alarm_irq_router.sv
module alarm_irq_router
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TIME_W-1:0] t_sec,
  input  logic [TIME_W-1:0] t_min,
  input  logic [TIME_W-1:0] t_hour,
  input  logic [WDAY_W-1:0] t_wday,
  input  logic [DATE_W-1:0] t_date,
  input  logic              tap_32k,
  input  logic              tap_8k,
  input  logic              tap_4k,
  input  logic              tap_1hz,
  input  logic              osc_running,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              osc_stop,
  output logic              out1_pd,
  output logic              out2_pd
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sh;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= '0;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_i_n = rst_sh[1];

  // alarm register bank
  logic [DATA_W-1:0] alm_q [NUM_ALM];

  for (genvar gi = 0; gi < NUM_ALM; gi++) begin : g_alm
    logic wr_en;
    assign wr_en = reg_we && (reg_addr == ADDR_W'(gi));
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)   alm_q[gi] <= '0;
      else if (wr_en) alm_q[gi] <= reg_wdata;
    end
  end

  // control register
  logic [DATA_W-1:0] ctrl_q;
  logic              ctrl_en;

  assign ctrl_en = reg_we && (reg_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     ctrl_q <= CTRL_RESET;
    else if (ctrl_en) ctrl_q <= reg_wdata & CTRL_KEEP;
  end

  // comparators
  logic m1, m2;

  alarm_match u_m1 (
    .sec_byte (alm_q[0]), .min_byte (alm_q[1]),
    .hour_byte(alm_q[2]), .dd_byte  (alm_q[3]),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .t_wday(t_wday), .t_date(t_date), .hit(m1)
  );

  // alarm 2 has no seconds byte: it compares seconds against 00, unmasked
  alarm_match u_m2 (
    .sec_byte ('0),       .min_byte (alm_q[4]),
    .hour_byte(alm_q[5]), .dd_byte  (alm_q[6]),
    .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour),
    .t_wday(t_wday), .t_date(t_date), .hit(m2)
  );

  // status register: next state
  logic a1f_q, a2f_q, osf_q;
  logic a1f_d, a2f_d, osf_d;
  logic stat_wr;

  always_comb begin
    stat_wr = reg_we && (reg_addr == ADDR_STAT);
    a1f_d = (a1f_q && !(stat_wr && !reg_wdata[SB_A1])) || (tick && m1);
    a2f_d = (a2f_q && !(stat_wr && !reg_wdata[SB_A2])) || (tick && m2);
    osf_d = !osc_running || (osf_q && !(stat_wr && !reg_wdata[SB_OSF]));
  end

  // status register: state
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      a1f_q <= 1'b0;
      a2f_q <= 1'b0;
      osf_q <= 1'b1;
    end else begin
      a1f_q <= a1f_d;
      a2f_q <= a2f_d;
      osf_q <= osf_d;
    end
  end

  // output routing
  irq_route u_route (
    .taps   ({tap_32k, tap_8k, tap_4k, tap_1hz}),
    .rate   (ctrl_q[CB_RATE_LO +: RATE_W]),
    .sep    (ctrl_q[CB_SEP]),
    .req1   (a1f_q && ctrl_q[CB_IE1]),
    .req2   (a2f_q && ctrl_q[CB_IE2]),
    .out1_pd(out1_pd),
    .out2_pd(out2_pd)
  );

  assign osc_stop = ctrl_q[CB_OSC_STOP];

  // read mux
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_ALM; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = alm_q[i];
    if (reg_addr == ADDR_CTRL) reg_rdata = ctrl_q;
    if (reg_addr == ADDR_STAT) begin
      reg_rdata[SB_OSF] = osf_q;
      reg_rdata[SB_A2]  = a2f_q;
      reg_rdata[SB_A1]  = a1f_q;
    end
  end
endmodule

// File: rtl/alarm_irq_router_chk.sv
module alarm_irq_router_chk
  import alm_pkg::*;
(
  input logic              clk,
  input logic              rst_i_n,
  input logic              tick,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wd_a1,
  input logic              wd_a2,
  input logic              wd_osf,
  input logic              osc_running,
  input logic              a1f_q,
  input logic              a2f_q,
  input logic              osf_q,
  input logic              sep,
  input logic              ie1,
  input logic              ie2,
  input logic              out1_pd,
  input logic              out2_pd
);
  logic swr;
  assign swr = reg_we && (reg_addr == ADDR_STAT);

  p_sticky_a1_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (a1f_q && !swr) |=> a1f_q);

  p_notick_a2_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!a2f_q && !tick) |=> !a2f_q);

  p_clear_a1_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (swr && !wd_a1 && !tick) |=> !a1f_q);

  p_clear_a2_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (swr && !wd_a2 && !tick) |=> !a2f_q);

  p_osf_set_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !osc_running |=> osf_q);

  p_osf_clear_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (swr && !wd_osf && osc_running) |=> !osf_q);

  p_shared_out2_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sep |-> (out2_pd == ((a1f_q && ie1) || (a2f_q && ie2))));

  p_sep_outs_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    sep |-> ((out1_pd == (a2f_q && ie2)) && (out2_pd == (a1f_q && ie1))));
endmodule

bind alarm_irq_router alarm_irq_router_chk u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .tick(tick),
  .reg_we(reg_we), .reg_addr(reg_addr),
  .wd_a1(reg_wdata[0]), .wd_a2(reg_wdata[1]), .wd_osf(reg_wdata[7]),
  .osc_running(osc_running),
  .a1f_q(a1f_q), .a2f_q(a2f_q), .osf_q(osf_q),
  .sep(ctrl_q[2]), .ie1(ctrl_q[0]), .ie2(ctrl_q[1]),
  .out1_pd(out1_pd), .out2_pd(out2_pd)
);

// File: tb/test_alarm_irq_router.sv
module test_alarm_irq_router;
  logic clk = 1'b0;
  logic rst_n, tick, osc_running, reg_we;
  logic [6:0] t_sec, t_min, t_hour;
  logic [2:0] t_wday;
  logic [5:0] t_date;
  logic tap_32k, tap_8k, tap_4k, tap_1hz;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic osc_stop, out1_pd, out2_pd;

  int n_cmp = 0, n_bad = 0;

  logic [7:0] m_alm [7];
  logic [7:0] m_ctrl;
  logic m_a1, m_a2, m_osf;

  always #5 clk = ~clk;

  alarm_irq_router i_alarm_irq_router (.*);

  function automatic bit f_hit(input [7:0] s, mi, h, dd,
                               input [6:0] ts, tm, th,
                               input [2:0] tw, input [5:0] td);
    bit cal;
    cal = dd[6] ? (dd[2:0] == tw) : (dd[5:0] == td);
    return (s[7] || s[6:0] == ts) && (mi[7] || mi[6:0] == tm) &&
           (h[7] || h[6:0] == th) && (dd[7] || cal);
  endfunction

  function automatic logic [7:0] f_stat();
    return {m_osf, 5'b0, m_a2, m_a1};
  endfunction

  function automatic logic [1:0] f_pins();
    logic [3:0] tp;
    logic w, q1, q2;
    tp = {tap_32k, tap_8k, tap_4k, tap_1hz};
    w  = tp[m_ctrl[4:3]];
    q1 = m_a1 && m_ctrl[0];
    q2 = m_a2 && m_ctrl[1];
    if (m_ctrl[2]) return {q2, q1};
    return {!w, q1 || q2};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pins_chk(input string tag);
    #1;
    chk(tag, {6'b0, out1_pd, out2_pd}, {6'b0, f_pins()});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < 4'd7) m_alm[a] = d;
    if (a == 4'd7) m_ctrl = d & 8'h9F;
    if (a == 4'd8) begin
      if (!d[0]) m_a1 = 1'b0;
      if (!d[1]) m_a2 = 1'b0;
      if (!d[7] && osc_running) m_osf = 1'b0;
    end
  endtask

  task automatic tk(input [6:0] s, m, h, input [2:0] w, input [5:0] dt);
    @(negedge clk);
    t_sec = s; t_min = m; t_hour = h; t_wday = w; t_date = dt; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    if (f_hit(m_alm[0], m_alm[1], m_alm[2], m_alm[3], s, m, h, w, dt)) m_a1 = 1'b1;
    if (f_hit(8'h00, m_alm[4], m_alm[5], m_alm[6], s, m, h, w, dt)) m_a2 = 1'b1;
  endtask

  task automatic set_taps(input logic [3:0] v);
    {tap_32k, tap_8k, tap_4k, tap_1hz} = v;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    rst_n = 1'b0; tick = 1'b0; osc_running = 1'b1; reg_we = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    t_sec = '0; t_min = '0; t_hour = '0; t_wday = 3'd1; t_date = 6'd1;
    set_taps(4'b0000);
    for (int i = 0; i < 7; i++) m_alm[i] = 8'h00;
    m_ctrl = 8'h18; m_a1 = 1'b0; m_a2 = 1'b0; m_osf = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_chk(4'd7, 8'h18, "R1 ctrl reset");
    rd_chk(4'd8, 8'h80, "R1 status reset");
    rd_chk(4'd0, 8'h00, "R1 alarm reset");
    rd_chk(4'd12, 8'h00, "R1 unmapped read");
    pins_chk("R8 reset pins, wave low");
    chk("R11 osc_stop reset", {7'b0, osc_stop}, 8'h00);

    // R10 oscillator-fail flag
    wr(4'd8, 8'h00);
    rd_chk(4'd8, 8'h00, "R10 clear while running");
    osc_running = 1'b0; m_osf = 1'b1;
    @(negedge clk);
    osc_running = 1'b1;
    rd_chk(4'd8, 8'h80, "R10 set on missing oscillation");
    osc_running = 1'b0;
    wr(4'd8, 8'h00);
    rd_chk(4'd8, 8'h80, "R10 clear blocked while stopped");
    osc_running = 1'b1;
    wr(4'd8, 8'h00);
    rd_chk(4'd8, 8'h00, "R10 clear after restart");

    // R11 control bits
    wr(4'd7, 8'h98);
    chk("R11 osc_stop follows bit 7", {7'b0, osc_stop}, 8'h01);
    wr(4'd7, 8'hFF);
    rd_chk(4'd7, 8'h9F, "R11 unused control bits");
    wr(4'd8, 8'hFF);
    rd_chk(4'd8, 8'h00, "R11 R6 status write of ones");
    wr(4'd5, 8'hA5);
    rd_chk(4'd5, 8'hA5, "R2 alarm readback");
    wr(4'd7, 8'h03);

    // R4 all-masked behaviour
    for (int i = 0; i < 7; i++) wr(4'(i), 8'h80);
    tk(7'h17, 7'h42, 7'h09, 3'd5, 6'h11);
    rd_chk(4'd8, 8'h01, "R4 alarm1 every tick, alarm2 off at sec 17");
    pins_chk("R8 shared out2 asserted");
    tk(7'h00, 7'h43, 7'h09, 3'd5, 6'h11);
    rd_chk(4'd8, 8'h03, "R4 alarm2 at seconds 00");

    // R6 partial clear
    wr(4'd8, 8'h82);
    rd_chk(4'd8, 8'h02, "R6 clear alarm1 only");
    wr(4'd8, 8'h00);
    rd_chk(4'd8, 8'h00, "R6 clear alarm2");

    // R5 no evaluation without tick
    t_sec = 7'h00;
    repeat (4) @(negedge clk);
    rd_chk(4'd8, 8'h00, "R5 matching fields without tick");

    // R3 day/date select, R2 field compare
    wr(4'd0, 8'h80); wr(4'd1, 8'h30); wr(4'd2, 8'h11); wr(4'd3, 8'h43);
    tk(7'h05, 7'h30, 7'h11, 3'd3, 6'h09);
    rd_chk(4'd8, 8'h01, "R3 weekday compare hit");
    wr(4'd8, 8'h00);
    tk(7'h05, 7'h30, 7'h11, 3'd4, 6'h03);
    rd_chk(4'd8, 8'h00, "R3 weekday compare ignores date");
    wr(4'd3, 8'h21);
    tk(7'h05, 7'h30, 7'h11, 3'd1, 6'h21);
    rd_chk(4'd8, 8'h01, "R3 date compare hit");
    wr(4'd8, 8'h00);
    tk(7'h05, 7'h31, 7'h11, 3'd1, 6'h21);
    rd_chk(4'd8, 8'h00, "R2 minute mismatch blocks");

    // R7 rate select with routing 0
    for (int r = 0; r < 4; r++) begin
      wr(4'd7, 8'(r << 3));
      set_taps(4'(1 << r));
      pins_chk($sformatf("R7 rate %0d tap high", r));
      set_taps(~4'(1 << r));
      pins_chk($sformatf("R7 rate %0d tap low", r));
    end

    // R9 separate routing
    wr(4'd7, 8'h07);
    for (int i = 0; i < 7; i++) wr(4'(i), 8'h80);
    tk(7'h00, 7'h00, 7'h00, 3'd1, 6'h01);
    pins_chk("R9 both flags separate outputs");
    wr(4'd8, 8'h01);
    pins_chk("R9 alarm1 only on out2");
    wr(4'd7, 8'h05);
    tk(7'h00, 7'h01, 7'h00, 3'd1, 6'h01);
    pins_chk("R9 alarm2 disabled keeps out1 released");
    wr(4'd8, 8'h00);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 20;
      set_taps(4'($urandom));
      if (op < 5) begin
        logic [7:0] v;
        v = 8'($urandom % 3);
        if ($urandom % 2) v[7] = 1'b1;
        if ($urandom % 2) v[6] = 1'b1;
        wr(4'($urandom % 7), v);
      end else if (op < 7) begin
        wr(4'd7, 8'($urandom));
      end else if (op < 9) begin
        wr(4'd8, 8'($urandom));
      end else begin
        tk(7'($urandom % 3), 7'($urandom % 3), 7'($urandom % 3),
           3'($urandom % 3), 6'($urandom % 3));
      end
      rd_chk(4'd8, f_stat(), "R5 R6 random status");
      pins_chk("R8 R9 random pins");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule